// File: doc/BRIEF.md
# Bus Cycle Time-out Monitor

This block times each bus cycle that the local processor starts toward the external bus. It counts system clocks from the start of the cycle until a data-transfer acknowledge arrives. If no acknowledge has arrived when the count reaches a programmable limit, the block pulses a bus-error output for one clock. The limit comes from a 2-bit period select. An enable input switches the whole function on or off.

Cycles started by other bus masters are not timed. Any bus that has other masters needs its own external monitor for those cycles. A word sent to an 8-bit port is carried out as two byte accesses. For such a word the timer runs across both accesses and does not restart between them. The limit must therefore allow for two byte accesses.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: The period select picks the limit L as 64 clocks for code 0, 32 for code 1, 16 for code 2 and 8 for code 3. In general, L equals the parameter BASE_CLKS (default 8) shifted left by (3 - code).
- R2: A monitored cycle starts when `cyc_start_i`, `cpu_owned_i` and `mon_en_i` are all high on a rising edge, called edge 0. If no acknowledge is sampled on edges 1 to L, `berr_o` is high for the clock that follows edge L.
- R3: An acknowledge sampled on any of edges 1 to L ends the cycle without a bus error. This includes an acknowledge on edge L itself, the same edge as the terminal count.
- R4: When `mon_en_i` is low, no cycle starts and `berr_o` stays low.
- R5: A start with `cpu_owned_i` low is not timed. An acknowledge while no cycle is active has no effect.
- R6: If `word_i` and `port8_i` are both high at the start, the cycle is a split word and needs two acknowledges. The count continues through the first acknowledge. An error is raised unless the second acknowledge is sampled by edge L. A split word whose two byte accesses both complete within L edges raises no error.
- R7: In a split word, a first acknowledge on edge L holds the count at the limit. If the second acknowledge is not sampled on edge L+1, the error follows edge L+1.
- R8: A word transfer to a 16-bit port (`word_i` high, `port8_i` low) completes on its first acknowledge.
- R9: The limit is captured at the start edge. A change to the period select during a cycle has no effect until the next cycle.
- R10: A start pulse while a cycle is active does not restart the count.
- R11: `rst` is a synchronous, active-high reset. It clears the count, the byte phase and `berr_o`, and abandons any active cycle.
- R12: Clearing `mon_en_i` during a cycle abandons that cycle with no error.
- R13: `berr_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start_i | input | 1 | Bus cycle begins on this clock |
| cpu_owned_i | input | 1 | The cycle was started by the local processor |
| port8_i | input | 1 | Target port is 8 bits wide |
| word_i | input | 1 | Transfer is a 16-bit word |
| ack_i | input | 1 | Data-transfer acknowledge |
| mon_en_i | input | 1 | Monitor enable |
| period_sel_i | input | 2 | Time-out period select |
| berr_o | output | 1 | One-clock bus-error pulse on time-out |

## Verification
The bound checker tests the following on every clock:
- the error pulse lasts one clock (R13);
- an acknowledge or a cleared enable on one edge means no error on the next clock (R3, R4);
- an untracked start leaves the monitor idle (R5);
- reset clears the output (R11);
- every error follows an active cycle.

The exact edge on which the error appears can only be shown by the bench's scenarios. The bench sweeps every period code against every acknowledge delay around the limit (R1, R2, R3). Other scenarios cover the following:
- the split-word timing and the saturation when the first acknowledge lands on the terminal edge (R6, R7);
- the period captured at the start edge (R9);
- restarts ignored during a cycle (R10);
- cycles abandoned by a cleared enable or by reset (R11, R12).

// File: rtl/bcw_pkg.sv
package bcw_pkg;

    typedef struct packed {
        logic active;   // a monitored cycle is in progress
        logic split;    // word to an 8-bit port: two acknowledges needed
        logic phase2;   // first byte already acknowledged
        logic berr;     // registered error pulse
    } ctl_t;

    localparam ctl_t CTL_RESET = '{active: 1'b0, split: 1'b0, phase2: 1'b0, berr: 1'b0};

endpackage

// File: rtl/bcw_period_dec.sv
module bcw_period_dec #(
    parameter int BASE_CLKS = 8,
    parameter int SEL_W     = 2,
    parameter int CNT_W     = 7
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] limit_o
);
    localparam int NCODES = 1 << SEL_W;

    logic [CNT_W-1:0] tab [NCODES];

    // code 0 is the longest period; each higher code halves it
    for (genvar i = 0; i < NCODES; i++) begin : g_tab
        assign tab[i] = CNT_W'(BASE_CLKS << (NCODES - 1 - i));
    end

    assign limit_o = tab[sel_i];
endmodule

// File: rtl/bcw_span_counter.sv
module bcw_span_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             at_limit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } cstate_t;

    cstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.cnt = CNT_W'(1);
            s_d.lim = limit_i;          // period captured at cycle start
        end else if (clr_i) begin
            s_d.cnt = '0;
        end else if (inc_i && (s_q.cnt != s_q.lim)) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);  // saturates at the limit
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign at_limit_o = (s_q.cnt == s_q.lim) && (s_q.cnt != '0);
endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog #(
    parameter int BASE_CLKS = 8,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start_i,
    input  logic             cpu_owned_i,
    input  logic             port8_i,
    input  logic             word_i,
    input  logic             ack_i,
    input  logic             mon_en_i,
    input  logic [SEL_W-1:0] period_sel_i,
    output logic             berr_o
);
    import bcw_pkg::*;

    localparam int MAX_LIM = BASE_CLKS << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    ctl_t st_d, st_q;

    logic             load, clr, inc, at_limit;
    logic [CNT_W-1:0] limit_new;

    bcw_period_dec #(.BASE_CLKS(BASE_CLKS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_dec (
        .sel_i   (period_sel_i),
        .limit_o (limit_new)
    );

    bcw_span_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .clr_i      (clr),
        .inc_i      (inc),
        .limit_i    (limit_new),
        .at_limit_o (at_limit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.berr = 1'b0;
        load      = 1'b0;
        clr       = 1'b0;
        inc       = 1'b0;
        if (!st_q.active) begin
            if (cyc_start_i && cpu_owned_i && mon_en_i) begin
                st_d.active = 1'b1;
                st_d.split  = word_i && port8_i;
                st_d.phase2 = 1'b0;
                load        = 1'b1;
            end
        end else if (!mon_en_i) begin
            st_d.active = 1'b0;
            clr         = 1'b1;
        end else if (ack_i) begin
            // acknowledge beats the terminal count
            if (st_q.split && !st_q.phase2) begin
                st_d.phase2 = 1'b1;
                inc         = 1'b1;
            end else begin
                st_d.active = 1'b0;
                clr         = 1'b1;
            end
        end else if (at_limit) begin
            st_d.berr   = 1'b1;
            st_d.active = 1'b0;
            clr         = 1'b1;
        end else begin
            inc = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CTL_RESET;
        else     st_q <= st_d;
    end

    assign berr_o = st_q.berr;
endmodule

// File: rtl/bcw_chk.sv
module bcw_chk (
    input logic clk,
    input logic rst,
    input logic cyc_start_i,
    input logic cpu_owned_i,
    input logic ack_i,
    input logic mon_en_i,
    input logic active,
    input logic berr_o
);
    // R13
    berr_single_chk: assert property (@(posedge clk) disable iff (rst)
        berr_o |=> !berr_o);

    // R3
    ack_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> !berr_o);

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !mon_en_i |=> !berr_o);

    // R5
    foreign_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && cyc_start_i && !cpu_owned_i) |=> !active);

    // R2
    berr_after_active_chk: assert property (@(posedge clk) disable iff (rst)
        berr_o |-> $past(active));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !berr_o);
endmodule

bind bus_cycle_watchdog bcw_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cyc_start_i (cyc_start_i),
    .cpu_owned_i (cpu_owned_i),
    .ack_i       (ack_i),
    .mon_en_i    (mon_en_i),
    .active      (st_q.active),
    .berr_o      (berr_o)
);

// File: tb/tb_bus_cycle_watchdog.sv
module tb_bus_cycle_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int NEVER      = 999;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0, cpu_owned = 1'b0, port8 = 1'b0, word = 1'b0;
    logic       ack = 1'b0, mon_en = 1'b1;
    logic [1:0] period_sel = 2'd0;
    logic       berr;

    int total = 0;
    int bad   = 0;

    bus_cycle_watchdog dut (
        .clk          (clk),
        .rst          (rst),
        .cyc_start_i  (cyc_start),
        .cpu_owned_i  (cpu_owned),
        .port8_i      (port8),
        .word_i       (word),
        .ack_i        (ack),
        .mon_en_i     (mon_en),
        .period_sel_i (period_sel),
        .berr_o       (berr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic int lim_of(input int sel);
        return 8 << (3 - sel);   // R1
    endfunction

    // expected edge of the error, 0 = none
    function automatic int exp_edge(input int sel, input int split, input int d1, input int d2);
        int l, t;
        l = lim_of(sel);
        t = split ? d1 + d2 : d1;
        if (t <= l) return 0;
        if (split && d1 == l) return l + 1;   // R7
        return l;
    endfunction

    task automatic run(input int sel, input int cpu, input int en, input int wd, input int p8,
                       input int d1, input int d2, input int chg_k, input int rs_k,
                       input int dis_k, input int exp_e, input string tag);
        int hi = 0;
        int first = 0;
        int win;
        win = ((d1 + d2 < 200) ? d1 + d2 : 0) + 72;
        @(negedge clk);
        period_sel = 2'(sel); cyc_start = 1'b1; cpu_owned = cpu[0]; mon_en = en[0];
        word = wd[0]; port8 = p8[0]; ack = 1'b0;
        @(posedge clk);   // edge 0
        for (int k = 1; k <= win + 1; k++) begin
            @(negedge clk);
            if (k > 1 && berr) begin
                hi++;
                if (first == 0) first = k - 1;
            end
            cyc_start = (k == rs_k);
            if (k == chg_k) period_sel = 2'(3 - sel);
            if (k == dis_k) mon_en = 1'b0;
            ack = (k == d1) || (wd != 0 && p8 != 0 && k == d1 + d2);
            @(posedge clk);
        end
        @(negedge clk);
        cyc_start = 1'b0; ack = 1'b0; mon_en = 1'b1; word = 1'b0; port8 = 1'b0;
        total++;
        if (exp_e == 0 ? (hi != 0) : (hi != 1 || first != exp_e)) begin
            bad++;
            $display("FAIL %s sel=%0d d1=%0d d2=%0d: actual pulses=%0d at %0d expected pulses=%0d at %0d",
                     tag, sel, d1, d2, hi, first, (exp_e != 0), exp_e);
        end
    endtask

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        total++;
        if (berr !== 1'b0) begin
            bad++; $display("FAIL R11 reset: actual berr=%b expected 0", berr);
        end
        rst = 1'b0;

        // R1 R2 R3: every code, every single-access delay around the limit
        for (int s = 0; s < 4; s++)
            for (int d = 1; d <= lim_of(s) + 2; d++)
                run(s, 1, 1, 0, 0, d, 0, 0, 0, 0, exp_edge(s, 0, d, 0), "R1/R2/R3 single");
        for (int s = 0; s < 4; s++)
            run(s, 1, 1, 0, 0, NEVER, 0, 0, 0, 0, lim_of(s), "R2 no ack");

        // R6 R7 split words
        for (int s = 0; s < 4; s++) begin
            int l;
            l = lim_of(s);
            run(s, 1, 1, 1, 1, l/2, l/2, 0, 0, 0, exp_edge(s, 1, l/2, l/2), "R6 split fits");
            run(s, 1, 1, 1, 1, 3, l - 3, 0, 0, 0, exp_edge(s, 1, 3, l - 3), "R6 split at limit");
            run(s, 1, 1, 1, 1, l/2, l/2 + 1, 0, 0, 0, exp_edge(s, 1, l/2, l/2 + 1), "R6 split late");
            run(s, 1, 1, 1, 1, 1, NEVER, 0, 0, 0, l, "R6 second missing");
            run(s, 1, 1, 1, 1, l, 1, 0, 0, 0, 0, "R7 first at limit, second next");
            run(s, 1, 1, 1, 1, l, 3, 0, 0, 0, l + 1, "R7 first at limit, second late");
        end

        // R8 word to 16-bit port
        run(3, 1, 1, 1, 0, 5, 0, 0, 0, 0, 0, "R8 word 16-bit");
        run(3, 1, 1, 1, 0, 9, 0, 0, 0, 0, 8, "R8 word 16-bit late");

        // R4 R5
        run(3, 1, 0, 0, 0, NEVER, 0, 0, 0, 0, 0, "R4 disabled");
        run(3, 0, 1, 0, 0, NEVER, 0, 0, 0, 0, 0, "R5 foreign master");
        run(2, 0, 1, 0, 0, 4, 0, 0, 0, 0, 0, "R5 ack while idle");

        // R9 period captured at start
        run(3, 1, 1, 0, 0, NEVER, 0, 2, 0, 0, 8, "R9 change 8->64");
        run(0, 1, 1, 0, 0, NEVER, 0, 2, 0, 0, 64, "R9 change 64->8");

        // R10 restart ignored
        run(2, 1, 1, 0, 0, NEVER, 0, 0, 5, 0, 16, "R10 restart");

        // R12 disable mid-cycle
        run(3, 1, 1, 0, 0, NEVER, 0, 0, 0, 4, 0, "R12 disable mid");

        // R11 reset abandons an active cycle
        @(negedge clk);
        period_sel = 2'd3; cyc_start = 1'b1; cpu_owned = 1'b1; mon_en = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (berr) seen++;
        end
        total++;
        if (seen != 0) begin
            bad++; $display("FAIL R11 mid-cycle reset: actual pulses=%0d expected 0", seen);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule